// File: doc/BRIEF.md
# Rotary Pulse Dial Generator

This block turns dialed digits into loop-disconnect pulses on an active-low dial line, the way a rotary telephone opens and closes its loop. A digit code arrives with a one-cycle strobe while the block is ready. In a pulse mode the block opens the loop once per unit of the digit, closes it between openings, and then holds the loop closed for an interdigit gap before it accepts the next entry. The mute line is low for the whole pulse sequence so the speech path stays quiet.

The same dial line also carries hook-flash breaks of four selectable lengths, which work in tone mode as well, each followed by a one-second recovery. In lock mode the line is held open for 300 ms after the handset goes off hook. A pause entry code inserts a 3.6 s wait. All durations are counted in milliseconds from a prescaler of `CYC_PER_MS` clock cycles. The break and make widths follow the rate and ratio selections, which are sampled when a digit is accepted.

Top module: `pulse_dialer`

## Requirements
- R1: While `hook_off` is 0, from the next cycle on `dp_n` and `mute_n` are 1 and `ready` is 0; any sequence in progress is abandoned.
- R2: When `hook_off` rises with `lock_en` 0, `ready` is 1 the following cycle. With `lock_en` 1, `dp_n` is 0 and `ready` is 0 for 300 ms, and then `ready` becomes 1 with `dp_n` at 1.
- R3: `mode_sel` 2'b00 and 2'b11 select tone mode. In tone mode a digit code 0 to 9 produces no output: `ready`, `dp_n` and `mute_n` stay at 1.
- R4: In a pulse mode, digit N (1 to 9) yields N breaks on `dp_n`, and digit 0 yields 10 breaks.
- R5: With `rate_sel` 0 (10 pps) a break and the make after it last 60 ms and 40 ms when `mode_sel` is 2'b01, and 67 ms and 33 ms when it is 2'b10. With `rate_sel` 1 (20 pps) these are 30/20 ms and 33/17 ms.
- R6: After the last make, `dp_n` stays 1 for an interdigit gap of 800 ms at 10 pps or 400 ms at 20 pps. `ready` returns at the end of this gap.
- R7: `mute_n` is 0 from the cycle after a digit is accepted in a pulse mode until the end of the interdigit gap, and `ready` is 0 whenever `mute_n` is 0.
- R8: Digit code 4'hA is a pause entry in any mode. `ready` is 0 for 3600 ms while `dp_n` and `mute_n` stay 1. Codes 4'hB to 4'hF are ignored.
- R9: `flash_req` opens the line (`dp_n` 0) for 73, 100, 300 or 600 ms for `flash_sel` 2'b00, 2'b01, 2'b10 or 2'b11, in any mode. A 1000 ms gap follows with `dp_n` 1, and `ready` is 0 throughout. When `flash_req` and `dig_valid` arrive in the same cycle, the flash is taken.
- R10: `rate_sel` and `mode_sel` are sampled only when a digit is accepted. Changing them during a sequence does not alter its timing.
- R11: Outputs change in the cycle after the accepting edge, and a duration of D ms spans exactly D times `CYC_PER_MS` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hook_off | input | 1 | 1 when the handset is off hook |
| lock_en | input | 1 | Enables the 300 ms off-hook line hold |
| rate_sel | input | 1 | 0 selects 10 pps, 1 selects 20 pps |
| mode_sel | input | 2 | 00/11 tone, 01 pulse 40:60, 10 pulse 33:67 |
| dig_valid | input | 1 | Strobe for dig_code, taken only while ready |
| dig_code | input | 4 | Digit 0 to 9, 4'hA for a pause entry |
| flash_req | input | 1 | Flash request, taken only while ready |
| flash_sel | input | 2 | Flash break length select |
| dp_n | output | 1 | Dial pulse line, 0 means the loop is open |
| mute_n | output | 1 | Mute, 0 during pulse dialing |
| ready | output | 1 | Block can accept a digit or flash |

## Verification
The assertions assume that strobes are presented only while `ready` is 1 or are meant to be ignored. They also assume that every duration handed to the millisecond timer is nonzero, which the rate and flash tables guarantee for every select value. The bench raises each strobe for exactly one cycle on a falling edge. It changes `rate_sel` and `mode_sel` during a sequence only in the test that targets sampling at acceptance. It drops `hook_off` only in the on-hook and abort tests, so every measured pulse train runs undisturbed to its return of `ready`.

// File: rtl/dial_pkg.sv
package dial_pkg;

    typedef enum logic [3:0] {
        S_ONHOOK,
        S_HOLD,
        S_READY,
        S_BREAK,
        S_MAKE,
        S_GAP_DIGIT,
        S_PAUSE,
        S_FLASH,
        S_GAP_FLASH
    } dial_state_e;

    localparam logic [1:0] MODE_PULSE_40 = 2'b01;
    localparam logic [1:0] MODE_PULSE_33 = 2'b10;
    localparam logic [3:0] CODE_PAUSE    = 4'hA;
    localparam logic [3:0] CODE_MAX_DIG  = 4'd9;

    // number of loop openings for a decimal digit
    function automatic logic [3:0] break_count(input logic [3:0] code);
        return (code == 4'd0) ? 4'd10 : code;
    endfunction

endpackage

// File: rtl/dial_ms_timer.sv
module dial_ms_timer #(
    parameter int CYC_PER_MS = 1000,
    parameter int MS_W       = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            done
);
    localparam int CYC_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_ONE   = MS_W'(1);

    typedef struct packed {
        logic            run;
        logic [CYC_W-1:0] cyc;
        logic [MS_W-1:0]  ms;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        done = t_q.run && (t_q.cyc == CYC_LAST) && (t_q.ms == MS_ONE);
        if (load) begin
            t_d.run = 1'b1;
            t_d.cyc = '0;
            t_d.ms  = load_ms;
        end else if (t_q.run) begin
            if (t_q.cyc == CYC_LAST) begin
                t_d.cyc = '0;
                if (t_q.ms == MS_ONE) t_d.run = 1'b0;
                else                  t_d.ms  = t_q.ms - MS_ONE;
            end else begin
                t_d.cyc = t_q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R11
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_ms != '0));

    // R11
    running_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.run |-> (t_q.ms != '0));

    // R11
    stop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !t_q.run);

endmodule

// File: rtl/dial_rate_table.sv
module dial_rate_table #(
    parameter int SLOW_PPS    = 10,
    parameter int IDP_SLOW_MS = 800,
    parameter int FLASH0_MS   = 73,
    parameter int FLASH1_MS   = 100,
    parameter int FLASH2_MS   = 300,
    parameter int FLASH3_MS   = 600,
    parameter int MS_W        = 12
) (
    input  logic            rate_sel,
    input  logic [1:0]      mode_sel,
    input  logic [1:0]      flash_sel,
    output logic            pulse_en,
    output logic [MS_W-1:0] brk_ms,
    output logic [MS_W-1:0] mk_ms,
    output logic [MS_W-1:0] idp_ms,
    output logic [MS_W-1:0] flash_ms
);
    import dial_pkg::*;

    localparam int PER_SLOW  = 1000 / SLOW_PPS;
    localparam int PER_FAST  = PER_SLOW / 2;
    localparam int BRK40_S   = (PER_SLOW * 6) / 10;
    localparam int BRK40_F   = (PER_FAST * 6) / 10;
    localparam int BRK33_S   = (PER_SLOW * 2 + 1) / 3;
    localparam int BRK33_F   = (PER_FAST * 2 + 1) / 3;

    always_comb begin
        pulse_en = (mode_sel == MODE_PULSE_40) || (mode_sel == MODE_PULSE_33);
        if (mode_sel == MODE_PULSE_33) begin
            brk_ms = rate_sel ? MS_W'(BRK33_F) : MS_W'(BRK33_S);
            mk_ms  = rate_sel ? MS_W'(PER_FAST - BRK33_F) : MS_W'(PER_SLOW - BRK33_S);
        end else begin
            brk_ms = rate_sel ? MS_W'(BRK40_F) : MS_W'(BRK40_S);
            mk_ms  = rate_sel ? MS_W'(PER_FAST - BRK40_F) : MS_W'(PER_SLOW - BRK40_S);
        end
        idp_ms = rate_sel ? MS_W'(IDP_SLOW_MS / 2) : MS_W'(IDP_SLOW_MS);
        case (flash_sel)
            2'b00:   flash_ms = MS_W'(FLASH0_MS);
            2'b01:   flash_ms = MS_W'(FLASH1_MS);
            2'b10:   flash_ms = MS_W'(FLASH2_MS);
            default: flash_ms = MS_W'(FLASH3_MS);
        endcase
    end

endmodule

// File: rtl/dial_seq.sv
module dial_seq #(
    parameter int MS_W     = 12,
    parameter int HOLD_MS  = 300,
    parameter int PAUSE_MS = 3600,
    parameter int GAP_MS   = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hook_off,
    input  logic            lock_en,
    input  logic            pulse_en,
    input  logic            dig_valid,
    input  logic [3:0]      dig_code,
    input  logic            flash_req,
    input  logic [MS_W-1:0] brk_ms,
    input  logic [MS_W-1:0] mk_ms,
    input  logic [MS_W-1:0] idp_ms,
    input  logic [MS_W-1:0] flash_ms,
    input  logic            tmr_done,
    output logic            tmr_load,
    output logic [MS_W-1:0] tmr_ms,
    output logic            dp_n,
    output logic            mute_n,
    output logic            ready
);
    import dial_pkg::*;

    typedef struct packed {
        dial_state_e     st;
        logic [3:0]      left;
        logic [MS_W-1:0] brk;
        logic [MS_W-1:0] mk;
        logic [MS_W-1:0] idp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_ms   = '0;
        if (!hook_off) begin
            s_d.st = S_ONHOOK;
        end else begin
            case (s_q.st)
                S_ONHOOK: begin
                    if (lock_en) begin
                        s_d.st   = S_HOLD;
                        tmr_load = 1'b1;
                        tmr_ms   = MS_W'(HOLD_MS);
                    end else begin
                        s_d.st = S_READY;
                    end
                end
                S_HOLD: if (tmr_done) s_d.st = S_READY;
                S_READY: begin
                    if (flash_req) begin
                        s_d.st   = S_FLASH;
                        tmr_load = 1'b1;
                        tmr_ms   = flash_ms;
                    end else if (dig_valid) begin
                        if (dig_code == CODE_PAUSE) begin
                            s_d.st   = S_PAUSE;
                            tmr_load = 1'b1;
                            tmr_ms   = MS_W'(PAUSE_MS);
                        end else if (pulse_en && (dig_code <= CODE_MAX_DIG)) begin
                            s_d.st   = S_BREAK;
                            s_d.left = break_count(dig_code);
                            s_d.brk  = brk_ms;
                            s_d.mk   = mk_ms;
                            s_d.idp  = idp_ms;
                            tmr_load = 1'b1;
                            tmr_ms   = brk_ms;
                        end
                    end
                end
                S_BREAK: begin
                    if (tmr_done) begin
                        s_d.st   = S_MAKE;
                        s_d.left = s_q.left - 4'd1;
                        tmr_load = 1'b1;
                        tmr_ms   = s_q.mk;
                    end
                end
                S_MAKE: begin
                    if (tmr_done) begin
                        tmr_load = 1'b1;
                        if (s_q.left == 4'd0) begin
                            s_d.st = S_GAP_DIGIT;
                            tmr_ms = s_q.idp;
                        end else begin
                            s_d.st = S_BREAK;
                            tmr_ms = s_q.brk;
                        end
                    end
                end
                S_FLASH: begin
                    if (tmr_done) begin
                        s_d.st   = S_GAP_FLASH;
                        tmr_load = 1'b1;
                        tmr_ms   = MS_W'(GAP_MS);
                    end
                end
                S_GAP_DIGIT, S_PAUSE, S_GAP_FLASH: if (tmr_done) s_d.st = S_READY;
                default: s_d.st = S_ONHOOK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_ONHOOK;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        dp_n   = !((s_q.st == S_HOLD) || (s_q.st == S_BREAK) || (s_q.st == S_FLASH));
        mute_n = !((s_q.st == S_BREAK) || (s_q.st == S_MAKE) || (s_q.st == S_GAP_DIGIT));
        ready  = (s_q.st == S_READY);
    end

    // R2
    lock_hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_ONHOOK && hook_off && lock_en) |=> (!dp_n && !ready));

    // R4
    break_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_BREAK) |-> (s_q.left != 4'd0 && s_q.left <= 4'd10));

    // R10
    timing_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_MAKE && hook_off) |=> $stable(s_q.brk) && $stable(s_q.mk) && $stable(s_q.idp));

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer #(
    parameter int CYC_PER_MS  = 1000,
    parameter int SLOW_PPS    = 10,
    parameter int IDP_SLOW_MS = 800,
    parameter int PAUSE_MS    = 3600,
    parameter int GAP_MS      = 1000,
    parameter int HOLD_MS     = 300,
    parameter int FLASH0_MS   = 73,
    parameter int FLASH1_MS   = 100,
    parameter int FLASH2_MS   = 300,
    parameter int FLASH3_MS   = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hook_off,
    input  logic       lock_en,
    input  logic       rate_sel,
    input  logic [1:0] mode_sel,
    input  logic       dig_valid,
    input  logic [3:0] dig_code,
    input  logic       flash_req,
    input  logic [1:0] flash_sel,
    output logic       dp_n,
    output logic       mute_n,
    output logic       ready
);
    import dial_pkg::*;

    localparam int MS_W = $clog2(PAUSE_MS + GAP_MS + IDP_SLOW_MS + FLASH3_MS + HOLD_MS + 1);

    logic            pulse_en;
    logic [MS_W-1:0] brk_ms, mk_ms, idp_ms, flash_ms, tmr_ms;
    logic            tmr_load, tmr_done;

    dial_rate_table #(
        .SLOW_PPS(SLOW_PPS), .IDP_SLOW_MS(IDP_SLOW_MS),
        .FLASH0_MS(FLASH0_MS), .FLASH1_MS(FLASH1_MS),
        .FLASH2_MS(FLASH2_MS), .FLASH3_MS(FLASH3_MS), .MS_W(MS_W)
    ) i_table (
        .rate_sel(rate_sel), .mode_sel(mode_sel), .flash_sel(flash_sel),
        .pulse_en(pulse_en), .brk_ms(brk_ms), .mk_ms(mk_ms),
        .idp_ms(idp_ms), .flash_ms(flash_ms)
    );

    dial_seq #(
        .MS_W(MS_W), .HOLD_MS(HOLD_MS), .PAUSE_MS(PAUSE_MS), .GAP_MS(GAP_MS)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .hook_off(hook_off), .lock_en(lock_en),
        .pulse_en(pulse_en), .dig_valid(dig_valid), .dig_code(dig_code),
        .flash_req(flash_req), .brk_ms(brk_ms), .mk_ms(mk_ms),
        .idp_ms(idp_ms), .flash_ms(flash_ms), .tmr_done(tmr_done),
        .tmr_load(tmr_load), .tmr_ms(tmr_ms),
        .dp_n(dp_n), .mute_n(mute_n), .ready(ready)
    );

    dial_ms_timer #(
        .CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_ms(tmr_ms), .done(tmr_done)
    );

    // R1
    onhook_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hook_off |=> (dp_n && mute_n && !ready));

    // R9
    flash_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hook_off && ready && flash_req) |=> (!dp_n && mute_n && !ready));

    // R3
    tone_digit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hook_off && ready && dig_valid && !flash_req && dig_code <= CODE_MAX_DIG
         && (mode_sel == 2'b00 || mode_sel == 2'b11)) |=> (ready && dp_n && mute_n));

    // R7
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hook_off && ready && dig_valid && !flash_req && dig_code <= CODE_MAX_DIG
         && (mode_sel == 2'b01 || mode_sel == 2'b10)) |=> (!dp_n && !mute_n && !ready));

    // R7
    mute_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |-> !ready);

endmodule

// File: tb/test_pulse_dialer.sv
module test_pulse_dialer;
    localparam int C = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hook_off = 1'b0, lock_en = 1'b0, rate_sel = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic dig_valid = 1'b0, flash_req = 1'b0;
    logic [3:0] dig_code = 4'd0;
    logic [1:0] flash_sel = 2'b00;
    logic dp_n, mute_n, ready;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pulse_dialer #(.CYC_PER_MS(C)) i_pulse_dialer (
        .clk(clk), .rst_n(rst_n), .hook_off(hook_off), .lock_en(lock_en),
        .rate_sel(rate_sel), .mode_sel(mode_sel), .dig_valid(dig_valid),
        .dig_code(dig_code), .flash_req(flash_req), .flash_sel(flash_sel),
        .dp_n(dp_n), .mute_n(mute_n), .ready(ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_brk(input logic [1:0] m, input logic r);
        if (m == 2'b10) return r ? 33 : 67;
        return r ? 30 : 60;
    endfunction

    function automatic int exp_mk(input logic [1:0] m, input logic r);
        if (m == 2'b10) return r ? 17 : 33;
        return r ? 20 : 40;
    endfunction

    task automatic strobe_digit(input logic [3:0] code);
        dig_code  = code;
        dig_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dig_valid = 1'b0;
    endtask

    // measure one pulse train; m/r are the settings in force at acceptance
    task automatic t_digit(input logic [1:0] m, input logic r, input logic [3:0] d,
                           input logic [1:0] m_late, input logic r_late, input string tag);
        int cyc = 0, lowrun = 0, highrun = 0, falls = 0, mutelow = 0, bad = 0;
        int b, k, g, n;
        logic prev = 1'b1;
        b = exp_brk(m, r) * C;
        k = exp_mk(m, r) * C;
        g = (r ? 400 : 800) * C;
        n = (d == 4'd0) ? 10 : int'(d);
        mode_sel = m; rate_sel = r;
        strobe_digit(d);
        mode_sel = m_late; rate_sel = r_late;
        while (!ready && cyc < 60000) begin
            if (!dp_n) begin
                if (prev) begin
                    falls++;
                    if (falls > 1 && highrun != k) bad++;
                    highrun = 0;
                end
                lowrun++;
            end else begin
                if (!prev) begin
                    if (lowrun != b) bad++;
                    lowrun = 0;
                end
                highrun++;
            end
            if (!mute_n) mutelow++;
            prev = dp_n;
            cyc++;
            @(negedge clk);
        end
        chk({tag, " R4 break count"}, falls, n);
        chk({tag, " R5 break/make widths off"}, bad, 0);
        chk({tag, " R6 make+gap tail"}, highrun, k + g);
        chk({tag, " R7 mute low cycles"}, mutelow, cyc);
        chk({tag, " R11 total busy cycles"}, cyc, n * (b + k) + g);
        mode_sel = m; rate_sel = r;
    endtask

    task automatic t_reset;
        chk("R1 reset dp_n", int'(dp_n), 1);
        chk("R1 reset mute_n", int'(mute_n), 1);
        chk("R1 reset ready", int'(ready), 0);
    endtask

    task automatic t_offhook_plain;
        lock_en = 1'b0;
        hook_off = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 ready after off hook", int'(ready), 1);
        chk("R2 dp_n after off hook", int'(dp_n), 1);
    endtask

    task automatic t_tone(input logic [1:0] m);
        mode_sel = m;
        strobe_digit(4'd5);
        for (int i = 0; i < 20; i++) begin
            if (!ready || !dp_n || !mute_n) begin
                chk("R3 tone digit ignored", 0, 1);
                break;
            end
            @(negedge clk);
        end
        chk("R3 tone ready", int'(ready), 1);
        chk("R3 tone dp_n", int'(dp_n), 1);
    endtask

    task automatic t_bad_code;
        mode_sel = 2'b01;
        strobe_digit(4'hC);
        repeat (10) @(negedge clk);
        chk("R8 code C ignored ready", int'(ready), 1);
        chk("R8 code C ignored dp_n", int'(dp_n), 1);
    endtask

    task automatic t_pause(input logic [1:0] m);
        int cyc = 0, bad = 0;
        mode_sel = m;
        strobe_digit(4'hA);
        while (!ready && cyc < 20000) begin
            if (!dp_n || !mute_n) bad++;
            cyc++;
            @(negedge clk);
        end
        chk("R8 pause length", cyc, 3600 * C);
        chk("R8 pause lines idle", bad, 0);
    endtask

    task automatic t_flash(input logic [1:0] sel, input logic [1:0] m);
        int lowc = 0, gapc = 0, bad = 0;
        int fms;
        fms = (sel == 2'b00) ? 73 : (sel == 2'b01) ? 100 : (sel == 2'b10) ? 300 : 600;
        mode_sel  = m;
        flash_sel = sel;
        flash_req = 1'b1;
        dig_valid = 1'b1;
        dig_code  = 4'd5;
        @(posedge clk);
        @(negedge clk);
        flash_req = 1'b0;
        dig_valid = 1'b0;
        while (!dp_n && lowc < 5000) begin
            if (ready || !mute_n) bad++;
            lowc++;
            @(negedge clk);
        end
        while (!ready && gapc < 5000) begin
            if (!dp_n || !mute_n) bad++;
            gapc++;
            @(negedge clk);
        end
        chk("R9 flash break length", lowc, fms * C);
        chk("R9 flash gap length", gapc, 1000 * C);
        chk("R9 flash lines/priority", bad, 0);
    endtask

    task automatic t_lock;
        int cyc = 0, bad = 0;
        hook_off = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 on hook ready", int'(ready), 0);
        lock_en  = 1'b1;
        hook_off = 1'b1;
        @(posedge clk);
        @(negedge clk);
        while (!ready && cyc < 5000) begin
            if (dp_n) bad++;
            cyc++;
            @(negedge clk);
        end
        chk("R2 lock hold length", cyc, 300 * C);
        chk("R2 lock hold dp_n low", bad, 0);
        chk("R2 dp_n after hold", int'(dp_n), 1);
        lock_en = 1'b0;
    endtask

    task automatic t_abort;
        mode_sel = 2'b01; rate_sel = 1'b0;
        strobe_digit(4'd9);
        repeat (50) @(negedge clk);
        hook_off = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 abort dp_n", int'(dp_n), 1);
        chk("R1 abort mute_n", int'(mute_n), 1);
        chk("R1 abort ready", int'(ready), 0);
        hook_off = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 ready again", int'(ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offhook_plain();
        t_digit(2'b01, 1'b0, 4'd1, 2'b01, 1'b0, "d1 10pps 40:60");
        t_digit(2'b10, 1'b0, 4'd0, 2'b10, 1'b0, "d0 10pps 33:67");
        t_digit(2'b01, 1'b1, 4'd7, 2'b01, 1'b1, "d7 20pps 40:60");
        t_digit(2'b10, 1'b1, 4'd3, 2'b10, 1'b1, "d3 20pps 33:67");
        t_digit(2'b01, 1'b0, 4'd2, 2'b10, 1'b1, "R10 late change");
        t_tone(2'b00);
        t_tone(2'b11);
        t_bad_code();
        t_pause(2'b00);
        t_pause(2'b01);
        t_flash(2'b00, 2'b00);
        t_flash(2'b01, 2'b01);
        t_flash(2'b10, 2'b10);
        t_flash(2'b11, 2'b00);
        t_lock();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule